// File: doc/BRIEF.md
# Chip Sequence Trigger Controller

This block decides when a chip-rate sequence generator begins and when it begins again. A trigger arrives either as an edge on an asynchronous external line, whose active polarity is selectable, or as a one-cycle manual pulse from the local control logic. A source-select input picks which of the two is listened to. Once a trigger is accepted, the block waits a programmable number of chips and then emits a one-cycle start pulse that tells the generator to begin again from its first frame.

Time inside the block is measured in chips, not clock cycles. A chip strobe input marks the clock cycles that carry a chip. Two modes exist. In retrigger mode every accepted trigger restarts the sequence. After each accepted trigger, a programmable window of chips blocks further triggers, and a zero window turns this blocking off. In single-shot mode only the first trigger is taken, and a re-arm pulse opens the block for the next one. A running flag tells the generator that at least one start has been issued since reset or since the last re-arm.

Top module: `chipseq_trig_ctrl`

## Requirements
- R1: With `src_ext_i`=1 only external edges act as triggers and manual pulses have no effect; with `src_ext_i`=0 only `man_trig_i` pulses act and the external line has no effect.
- R2: The external line passes through a two-flop synchronizer. An external edge driven before clock edge E0 is accepted at clock edge E2.
- R3: `edge_rise_i`=1 selects the low-to-high transition as the active edge and `edge_rise_i`=0 selects high-to-low. The other transition is ignored.
- R4: With delay value D and a chip strobe on every cycle, `start_o` is high for one cycle, starting one cycle after the (D+1)-th chip strobe that follows the accepting cycle. D=0 therefore starts on the first strobe after the trigger. Only cycles with `chip_en_i`=1 count.
- R5: A trigger accepted while a delay is still counting reloads the delay from its full value. The earlier pending start is dropped.
- R6: With inhibit value I>0, triggers are rejected until I chip strobes have passed after the accepting cycle. A trigger sampled in the same cycle as the I-th strobe is still rejected. I=0 rejects nothing.
- R7: The inhibit window counts from the accepted trigger, not from the start pulse, so it can expire while the delay is still running.
- R8: With `retrig_i`=0, the first accepted trigger disarms the block, and later triggers have no effect until `rearm_i`.
- R9: `start_o` never lasts more than one cycle. `running_o` rises with the first `start_o` and stays high until `rearm_i`. Both are 0 after reset.
- R10: A `rearm_i` pulse cancels any pending start, clears `running_o` on the next cycle and re-arms the block. A trigger in the same cycle as `rearm_i` is ignored.
- R11: In retrigger mode, a trigger accepted after a start produces another start, which restarts the sequence at frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_i | input | 1 | Chip strobe, one cycle per chip |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| man_trig_i | input | 1 | Manual trigger pulse |
| src_ext_i | input | 1 | 1 selects the external source, 0 selects the manual source |
| edge_rise_i | input | 1 | 1 selects the rising active edge, 0 selects the falling edge |
| retrig_i | input | 1 | 1 selects retrigger mode, 0 selects single-shot mode |
| rearm_i | input | 1 | Re-arm pulse; cancels a pending start and clears running |
| delay_chips_i | input | DLY_W | Chips to wait before the start |
| inhibit_chips_i | input | INH_W | Chips during which triggers are blocked; 0 turns blocking off |
| start_o | output | 1 | One-cycle start pulse (restart at frame 1) |
| running_o | output | 1 | Set by the first start, cleared by re-arm |

## Verification
The bench goes after the places where an off-by-one error would hide. It measures the start latency for delays of zero and non-zero on both sources; a design that counted the accepting cycle as a chip, or that dropped a synchronizer stage, starts one cycle early. It probes the inhibit boundary with a trigger on the last blocked strobe and another one strobe later; a design that reopens one strobe too soon gives an early restart, and one that counts from the start pulse misses the second trigger. It also checks a retrigger during the delay, a single-shot retrigger, and a re-arm issued during a delay or in the same cycle as a trigger, where a wrong design emits a start that should have been cancelled. A cycle-level model driven with constrained random stimulus then compares both outputs on every cycle.

// File: rtl/chipseq_trig_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the chip sequence trigger controller.
// Assumes: single-bit configuration inputs are cast to these types inside the block.
package chipseq_trig_pkg;

    // Which trigger source is listened to
    typedef enum logic {
        SRC_MANUAL   = 1'b0,
        SRC_EXTERNAL = 1'b1
    } trig_src_e;

    // Which transition of the external line counts as the trigger
    typedef enum logic {
        EDGE_FALLING = 1'b0,
        EDGE_RISING  = 1'b1
    } trig_edge_e;

    // Restart behaviour after the first accepted trigger
    typedef enum logic {
        MODE_SINGLE  = 1'b0,
        MODE_RETRIG  = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/chipseq_edge_det.sv
`timescale 1ns/1ps
// Module: chipseq_edge_det
// Synchronizes an asynchronous line through a chain of STAGES flops and
// flags the selected transition on the synchronized value for one cycle.
// Assumes: STAGES >= 2; the line is held low during reset.
module chipseq_edge_det
    import chipseq_trig_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic rise_sel_i,
    output logic edge_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              sync_w;
    trig_edge_e        edge_sel;

    // first synchronizer stage samples the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    // remaining synchronizer stages, one flop each
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_w = chain_q[STAGES-1];

    // hold the previous synchronized value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_w;
    end

    // pick the active transition
    always_comb begin
        edge_sel = trig_edge_e'(rise_sel_i);
        if (edge_sel == EDGE_RISING) edge_o = sync_w & ~prev_q;
        else                         edge_o = ~sync_w & prev_q;
    end

endmodule

// File: rtl/chipseq_chip_cnt.sv
`timescale 1ns/1ps
// Module: chipseq_chip_cnt
// Loadable down-counter in chips: load wins, otherwise it steps down on each
// tick until it reaches zero and then holds.
// Assumes: tick_i is already qualified by the chip strobe.
module chipseq_chip_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         zero_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // load or count down, saturating at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (load_i)                    cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/chipseq_start_seq.sv
`timescale 1ns/1ps
// Module: chipseq_start_seq
// Holds a pending start after an accepted trigger, counts the delay in chips
// and emits the registered start pulse; also keeps the running flag.
// Assumes: accept_i and cancel_i are never high together (the top gates them).
module chipseq_start_seq #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             cancel_i,
    input  logic             chip_en_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             start_o,
    output logic             running_o
);

    logic pending_q;
    logic dly_zero;
    logic dly_tick;
    logic fire;
    logic start_q;
    logic running_q;

    assign dly_tick = chip_en_i & pending_q & ~accept_i;
    assign fire     = pending_q & chip_en_i & ~accept_i & ~cancel_i & dly_zero;

    chipseq_chip_cnt #(.W(DLY_W)) u_dly_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept_i),
        .load_val_i (delay_i),
        .tick_i     (dly_tick),
        .zero_o     (dly_zero)
    );

    // pending flag: set on accept, cleared when the start fires or on cancel
    always_ff @(posedge clk) begin
        if (!rst_n)        pending_q <= 1'b0;
        else if (cancel_i) pending_q <= 1'b0;
        else if (accept_i) pending_q <= 1'b1;
        else if (fire)     pending_q <= 1'b0;
    end

    // registered one-cycle start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= fire;
    end

    // running flag: set by a start, cleared only by cancel
    always_ff @(posedge clk) begin
        if (!rst_n)        running_q <= 1'b0;
        else if (cancel_i) running_q <= 1'b0;
        else if (fire)     running_q <= 1'b1;
    end

    assign start_o   = start_q;
    assign running_o = running_q;

endmodule

// File: rtl/chipseq_trig_ctrl.sv
`timescale 1ns/1ps
// Module: chipseq_trig_ctrl (top)
// Selects the trigger source, gates triggers through the arm state and the
// inhibit window, and hands accepted triggers to the delayed-start sequencer.
// Assumes: configuration inputs are quasi-static; man_trig_i and rearm_i are
// single-cycle pulses in the clk domain; ext_trig_i is asynchronous.
module chipseq_trig_ctrl
    import chipseq_trig_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int INH_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en_i,
    input  logic             ext_trig_i,
    input  logic             man_trig_i,
    input  logic             src_ext_i,
    input  logic             edge_rise_i,
    input  logic             retrig_i,
    input  logic             rearm_i,
    input  logic [DLY_W-1:0] delay_chips_i,
    input  logic [INH_W-1:0] inhibit_chips_i,
    output logic             start_o,
    output logic             running_o
);

    logic       ext_edge;
    logic       trig_raw;
    logic       accept;
    logic       inh_idle;
    logic       armed_q;
    trig_src_e  src_sel;
    trig_mode_e mode_sel;

    chipseq_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_i    (ext_trig_i),
        .rise_sel_i (edge_rise_i),
        .edge_o     (ext_edge)
    );

    // source select and acceptance gate
    always_comb begin
        src_sel  = trig_src_e'(src_ext_i);
        mode_sel = trig_mode_e'(retrig_i);
        trig_raw = (src_sel == SRC_EXTERNAL) ? ext_edge : man_trig_i;
        accept   = trig_raw & ~rearm_i & inh_idle &
                   ((mode_sel == MODE_RETRIG) | armed_q);
    end

    // arm state: cleared by a single-shot acceptance, set by re-arm
    always_ff @(posedge clk) begin
        if (!rst_n)                               armed_q <= 1'b1;
        else if (rearm_i)                         armed_q <= 1'b1;
        else if (accept && mode_sel == MODE_SINGLE) armed_q <= 1'b0;
    end

    chipseq_chip_cnt #(.W(INH_W)) u_inh_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (inhibit_chips_i),
        .tick_i     (chip_en_i),
        .zero_o     (inh_idle)
    );

    chipseq_start_seq #(.DLY_W(DLY_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .cancel_i  (rearm_i),
        .chip_en_i (chip_en_i),
        .delay_i   (delay_chips_i),
        .start_o   (start_o),
        .running_o (running_o)
    );

endmodule

// File: rtl/chipseq_trig_ctrl_chk.sv
`timescale 1ns/1ps
// Module: chipseq_trig_ctrl_chk
// Port-level property checker for the trigger controller, bound to the top.
module chipseq_trig_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_en_i,
    input logic rearm_i,
    input logic start_o,
    input logic running_o
);

    // R4: a start only follows a cycle that carried a chip strobe
    a_r4_start_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(chip_en_i));

    // R9: the start pulse is one cycle wide
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R9: running is high whenever a start is issued
    a_r9_run_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> running_o);

    // R9: running stays high until a re-arm
    a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !rearm_i) |=> running_o);

    // R10: re-arm clears running and suppresses any start on the next cycle
    a_r10_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!running_o && !start_o));

endmodule

bind chipseq_trig_ctrl chipseq_trig_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_i (chip_en_i),
    .rearm_i   (rearm_i),
    .start_o   (start_o),
    .running_o (running_o)
);

// File: tb/tb_chipseq_trig_ctrl.sv
`timescale 1ns/1ps
module tb_chipseq_trig_ctrl;

    localparam int DW = 16;
    localparam int IW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en_i = 1'b1;
    logic          ext_trig_i = 1'b0;
    logic          man_trig_i = 1'b0;
    logic          src_ext_i = 1'b0;
    logic          edge_rise_i = 1'b1;
    logic          retrig_i = 1'b1;
    logic          rearm_i = 1'b0;
    logic [DW-1:0] delay_chips_i = '0;
    logic [IW-1:0] inhibit_chips_i = '0;
    logic          start_o;
    logic          running_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chipseq_trig_ctrl #(.DLY_W(DW), .INH_W(IW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .ext_trig_i(ext_trig_i),
        .man_trig_i(man_trig_i), .src_ext_i(src_ext_i), .edge_rise_i(edge_rise_i),
        .retrig_i(retrig_i), .rearm_i(rearm_i), .delay_chips_i(delay_chips_i),
        .inhibit_chips_i(inhibit_chips_i), .start_o(start_o), .running_o(running_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected latency in negedges from the trigger to the visible start
    function automatic int exp_lat(input bit use_ext, input int d, input int acc_off);
        return (use_ext ? 2 : 0) + acc_off + d + 2;
    endfunction

    // cycle model built from the requirements
    logic m_s0, m_s1, m_prev, m_armed, m_pend, m_start, m_run;
    int   m_inh, m_dcnt;
    always @(posedge clk) begin : model
        logic ev, raw, acc, fire;
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_prev = 0; m_armed = 1; m_pend = 0;
            m_start = 0; m_run = 0; m_inh = 0; m_dcnt = 0;
        end else begin
            ev   = edge_rise_i ? (m_s1 && !m_prev) : (!m_s1 && m_prev);
            raw  = src_ext_i ? ev : man_trig_i;
            acc  = raw && !rearm_i && (retrig_i || m_armed) && (m_inh == 0);
            fire = m_pend && chip_en_i && !acc && !rearm_i && (m_dcnt == 0);
            m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_trig_i;
            if (rearm_i) m_armed = 1;
            else if (acc && !retrig_i) m_armed = 0;
            if (acc) m_inh = int'(inhibit_chips_i);
            else if (chip_en_i && m_inh != 0) m_inh--;
            if (acc) m_dcnt = int'(delay_chips_i);
            else if (chip_en_i && m_pend && m_dcnt != 0) m_dcnt--;
            if (rearm_i) m_pend = 0;
            else if (acc) m_pend = 1;
            else if (fire) m_pend = 0;
            m_start = fire;
            if (rearm_i) m_run = 0;
            else if (fire) m_run = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 start_o vs model", int'(start_o), int'(m_start));
            chk("R9 running_o vs model", int'(running_o), int'(m_run));
        end
    end

    // fire one trigger (and optionally a second manual one at negedge index 'second')
    task automatic trig_lat(input bit use_ext, input int second, output int lat);
        @(negedge clk);
        if (use_ext) ext_trig_i = !ext_trig_i;
        else man_trig_i = 1'b1;
        lat = -1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            man_trig_i = (k == second);
            if (start_o && lat < 0) lat = k;
        end
        man_trig_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int lat;

    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset start_o", int'(start_o), 0);
        chk("R9 reset running_o", int'(running_o), 0);

        // R4: manual trigger, zero delay
        delay_chips_i = 0;
        trig_lat(0, 0, lat); chk("R4 latency D=0", lat, exp_lat(0, 0, 0));
        chk("R9 running after start", int'(running_o), 1);
        // R4 and R11: delay 3, second start in retrigger mode
        delay_chips_i = 3;
        trig_lat(0, 0, lat); chk("R4/R11 latency D=3 restart", lat, exp_lat(0, 3, 0));

        // R2: external rising edge through the synchronizer
        src_ext_i = 1; delay_chips_i = 2;
        trig_lat(1, 0, lat); chk("R2 external latency", lat, exp_lat(1, 2, 0));
        // R3: polarity
        trig_lat(1, 0, lat); chk("R3 falling ignored in rising mode", lat, -1);
        edge_rise_i = 0;
        trig_lat(1, 0, lat); chk("R3 rising ignored in falling mode", lat, -1);
        trig_lat(1, 0, lat); chk("R3 falling accepted", lat, exp_lat(1, 2, 0));
        // R1: source select
        trig_lat(0, 0, lat); chk("R1 manual ignored with external source", lat, -1);
        src_ext_i = 0;
        trig_lat(1, 0, lat); chk("R1 external ignored with manual source", lat, -1);

        // R5: retrigger during delay reloads the count
        delay_chips_i = 6;
        trig_lat(0, 3, lat); chk("R5 retrigger reloads delay", lat, exp_lat(0, 6, 3));
        // R6: inhibit boundary
        delay_chips_i = 8; inhibit_chips_i = 5;
        trig_lat(0, 5, lat); chk("R6 trigger on last inhibited strobe", lat, exp_lat(0, 8, 0));
        trig_lat(0, 6, lat); chk("R6 trigger after window", lat, exp_lat(0, 8, 6));
        inhibit_chips_i = 0;
        trig_lat(0, 1, lat); chk("R6 zero inhibit", lat, exp_lat(0, 8, 1));
        // R7: window counted from trigger, ends before the start
        delay_chips_i = 10; inhibit_chips_i = 3;
        trig_lat(0, 3, lat); chk("R7 inside window", lat, exp_lat(0, 10, 0));
        trig_lat(0, 4, lat); chk("R7 window ends before start", lat, exp_lat(0, 10, 4));

        // R8: single shot
        retrig_i = 0; inhibit_chips_i = 0; delay_chips_i = 1;
        trig_lat(0, 0, lat); chk("R8 first trigger", lat, exp_lat(0, 1, 0));
        trig_lat(0, 0, lat); chk("R8 later trigger ignored", lat, -1);
        @(negedge clk); rearm_i = 1;
        @(negedge clk); rearm_i = 0;
        chk("R10 running cleared by rearm", int'(running_o), 0);
        trig_lat(0, 0, lat); chk("R8/R10 trigger after rearm", lat, exp_lat(0, 1, 0));
        // R10: rearm cancels a pending start
        @(negedge clk); rearm_i = 1;
        @(negedge clk); rearm_i = 0;
        delay_chips_i = 20;
        @(negedge clk); man_trig_i = 1;
        @(negedge clk); man_trig_i = 0;
        idle(3);
        rearm_i = 1;
        @(negedge clk); rearm_i = 0;
        lat = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (start_o) lat++; end
        chk("R10 pending start cancelled", lat, 0);
        // R10: trigger in the rearm cycle is ignored
        delay_chips_i = 0;
        @(negedge clk); man_trig_i = 1; rearm_i = 1;
        @(negedge clk); man_trig_i = 0; rearm_i = 0;
        lat = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); if (start_o) lat++; end
        chk("R10 trigger with rearm ignored", lat, 0);

        // constrained random phase checked by the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            chip_en_i  = ($urandom % 3) != 0;
            if ($urandom % 7 == 0) ext_trig_i = !ext_trig_i;
            man_trig_i = ($urandom % 11) == 0;
            rearm_i    = ($urandom % 97) == 0;
            if ($urandom % 200 == 0) src_ext_i   = 1'($urandom);
            if ($urandom % 300 == 0) edge_rise_i = 1'($urandom);
            if ($urandom % 250 == 0) retrig_i    = 1'($urandom);
            if ($urandom % 150 == 0) begin
                delay_chips_i   = DW'($urandom % 8);
                inhibit_chips_i = IW'($urandom % 16);
            end
        end
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule